// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two IEEE-754 values and records the outcome as four condition flags in the top nibble of a 32-bit floating-point status register. It accepts single precision (32-bit) or double precision (64-bit) operands. A double operand is supplied as two 32-bit register words, a low word and a high word. A second mode compares the first operand against zero and ignores the second operand buses.

The compare has four outcomes: equal, less, greater and unordered. Each outcome maps to a fixed four-bit flag pattern. The ordering is worked out on sign and magnitude fields, with no floating-point subtraction. A NaN in either operand makes the result unordered, and zeros of either sign compare as equal. The status register is loaded one clock after a valid strobe, and only when the predicate input says the operation is allowed to execute.

Top module: `fpcmp_flag_unit`

## Requirements
- R1: Equal operands write flags {N,Z,C,V} = 4'b0110 into status bits 31:28 (N at bit 31, Z at 30, C at 29, V at 28).
- R2: When the first operand is less than the second, the flags are 4'b1000.
- R3: When the first operand is greater than the second, the flags are 4'b0010.
- R4: An operand whose exponent field is all ones and whose mantissa is nonzero is a NaN. If either operand is a NaN, the result is unordered and the flags are 4'b0011.
- R5: +0 and -0 compare as equal, in either order and in either precision.
- R6: Ordering follows sign-magnitude rules. A negative value is less than any positive value. Between two negative values, the larger magnitude is the smaller number. Infinities order beyond all finite values.
- R7: With dbl_sel=1, an operand is {hi word, lo word}, with the low word in bits 31:0 and the high word in bits 63:32. With dbl_sel=0, only the low words are compared and the high words have no effect.
- R8: With zero_sel=1, the second operand is replaced by +0 in both precisions, and b_lo and b_hi have no effect.
- R9: The flags change only when op_valid=1 and pred_ok=1 at a rising clock edge. In every other case status_q is left unchanged.
- R10: A flag update is visible on status_q right after the rising edge at which op_valid was sampled. Bits 27:0 never change from their reset value.
- R11: After reset, status_q is 32'h0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | A compare is presented this cycle |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision |
| zero_sel | input | 1 | 1 = compare first operand against zero |
| pred_ok | input | 1 | Predicate passed; allows the flag update |
| a_lo | input | 32 | First operand, low word (whole value in single) |
| a_hi | input | 32 | First operand, high word (double only) |
| b_lo | input | 32 | Second operand, low word |
| b_hi | input | 32 | Second operand, high word |
| status_q | output | 32 | Registered status register; flags in bits 31:28 |

## Verification
The bench targets the following corner cases:
- **Signed zeros.** A design that compares raw bits would report -0 against +0 as less or greater.
- **Pairs of negative values.** A design that orders by plain magnitude would swap less and greater.
- **NaN and infinity.** Infinity patterns, with exponent all ones and mantissa zero, sit next to NaN patterns that differ from them by one mantissa bit. A wrong NaN test would either call infinity unordered or order a NaN.
- **Double operands differing only in the low word.** Stale high words in single mode, and b buses carrying values in zero mode, expose a design that mixes up the words or leaks the ignored operand.
- **Predicate-failed and idle cycles.** These follow distinct updates, so a design that loads without both strobes would change the flags.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_LT = 2'd1,
    CMP_GT = 2'd2,
    CMP_UN = 2'd3
  } cmp_res_e;

  localparam int FLAG_W = 4;

  // Map a four-way outcome onto the {N,Z,C,V} nibble.
  function automatic logic [FLAG_W-1:0] nzcv_of(cmp_res_e r);
    case (r)
      CMP_EQ:  return 4'b0110;
      CMP_LT:  return 4'b1000;
      CMP_GT:  return 4'b0010;
      default: return 4'b0011;
    endcase
  endfunction

endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int OUT_W = 31
) (
  input  logic [EXP_W+MAN_W:0] val,
  output logic                 sign,
  output logic [OUT_W-1:0]     mag,
  output logic                 is_nan,
  output logic                 is_zero
);
  localparam int BODY_W = EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign sign    = val[BODY_W];
  assign exp_f   = val[BODY_W-1:MAN_W];
  assign man_f   = val[MAN_W-1:0];
  assign mag     = OUT_W'(val[BODY_W-1:0]);
  assign is_nan  = (&exp_f) && (|man_f);
  assign is_zero = ~|val[BODY_W-1:0];
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sign_a,
  input  logic [MAG_W-1:0] mag_a,
  input  logic             nan_a,
  input  logic             zero_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             nan_b,
  input  logic             zero_b,
  output cmp_res_e         res
);
  // Sign-magnitude ordering; a set sign flips the magnitude verdict.
  function automatic cmp_res_e rank(logic sa, logic [MAG_W-1:0] ma, logic na, logic za,
                                    logic sb, logic [MAG_W-1:0] mb, logic nb, logic zb);
    if (na || nb)          return CMP_UN;
    else if (za && zb)     return CMP_EQ;
    else if (sa != sb)     return sa ? CMP_LT : CMP_GT;
    else if (ma == mb)     return CMP_EQ;
    else if ((ma < mb) ^ sa) return CMP_LT;
    else                   return CMP_GT;
  endfunction

  logic any_nan, both_zero, neg_vs_pos;
  assign any_nan    = nan_a | nan_b;
  assign both_zero  = zero_a & zero_b;
  assign neg_vs_pos = sign_a & ~sign_b & ~any_nan & ~both_zero;

  assign res = rank(sign_a, mag_a, nan_a, zero_a, sign_b, mag_b, nan_b, zero_b);

  p_nan_unord_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_nan |-> res == CMP_UN);
  p_zero_eq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    both_zero && !any_nan |-> res == CMP_EQ);
  p_neg_below_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    neg_vs_pos |-> res == CMP_LT);
endmodule

// File: rtl/fpcmp_status.sv
module fpcmp_status
  import fpcmp_pkg::*;
#(
  parameter int          STAT_W  = 32,
  parameter logic [31:0] RST_VAL = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FLAG_W-1:0] nzcv_in,
  output logic [STAT_W-1:0] status_q
);
  localparam int TOP = STAT_W - 1;
  localparam int LOW_MSB = STAT_W - FLAG_W - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    status_q <= STAT_W'(RST_VAL);
    else if (load) status_q[TOP -: FLAG_W] <= nzcv_in;
  end

  logic [FLAG_W-1:0] flags_now;
  assign flags_now = status_q[TOP -: FLAG_W];

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(status_q));
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> flags_now == $past(nzcv_in));
  p_low_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[LOW_MSB:0] == RST_VAL[LOW_MSB:0]);
  p_legal_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flags_now inside {4'b0000, 4'b0110, 4'b1000, 4'b0010, 4'b0011});
endmodule

// File: rtl/fpcmp_flag_unit.sv
module fpcmp_flag_unit
  import fpcmp_pkg::*;
#(
  parameter int          WORD_W   = 32,
  parameter int          SP_EXP_W = 8,
  parameter int          SP_MAN_W = 23,
  parameter int          DP_EXP_W = 11,
  parameter int          DP_MAN_W = 52,
  parameter logic [31:0] RST_VAL  = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              dbl_sel,
  input  logic              zero_sel,
  input  logic              pred_ok,
  input  logic [WORD_W-1:0] a_lo,
  input  logic [WORD_W-1:0] a_hi,
  input  logic [WORD_W-1:0] b_lo,
  input  logic [WORD_W-1:0] b_hi,
  output logic [WORD_W-1:0] status_q
);
  localparam int DP_W  = 1 + DP_EXP_W + DP_MAN_W;
  localparam int SP_W  = 1 + SP_EXP_W + SP_MAN_W;
  localparam int MAG_W = DP_EXP_W + DP_MAN_W;

  // Operand words, index 0 = first, 1 = second (forced to +0 in zero mode).
  logic [1:0][WORD_W-1:0] lo_w, hi_w;
  assign lo_w[0] = a_lo;
  assign hi_w[0] = a_hi;
  assign lo_w[1] = zero_sel ? '0 : b_lo;
  assign hi_w[1] = zero_sel ? '0 : b_hi;

  logic [1:0]            sgn, nan, zer;
  logic [1:0][MAG_W-1:0] mag;

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    logic [DP_W-1:0]  raw_dp;
    logic [SP_W-1:0]  raw_sp;
    logic             s_sp, s_dp, n_sp, n_dp, z_sp, z_dp;
    logic [MAG_W-1:0] m_sp, m_dp;

    assign raw_dp = DP_W'({hi_w[k], lo_w[k]});
    assign raw_sp = lo_w[k][SP_W-1:0];

    fpcmp_unpack #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W), .OUT_W(MAG_W)) u_sp (
      .val(raw_sp), .sign(s_sp), .mag(m_sp), .is_nan(n_sp), .is_zero(z_sp));
    fpcmp_unpack #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W), .OUT_W(MAG_W)) u_dp (
      .val(raw_dp), .sign(s_dp), .mag(m_dp), .is_nan(n_dp), .is_zero(z_dp));

    assign sgn[k] = dbl_sel ? s_dp : s_sp;
    assign mag[k] = dbl_sel ? m_dp : m_sp;
    assign nan[k] = dbl_sel ? n_dp : n_sp;
    assign zer[k] = dbl_sel ? z_dp : z_sp;
  end

  cmp_res_e          res;
  logic [FLAG_W-1:0] nzcv;
  logic              load;

  fpcmp_order #(.MAG_W(MAG_W)) u_order (
    .clk(clk), .rst_n(rst_n),
    .sign_a(sgn[0]), .mag_a(mag[0]), .nan_a(nan[0]), .zero_a(zer[0]),
    .sign_b(sgn[1]), .mag_b(mag[1]), .nan_b(nan[1]), .zero_b(zer[1]),
    .res(res));

  assign nzcv = nzcv_of(res);
  assign load = op_valid & pred_ok;

  fpcmp_status #(.STAT_W(WORD_W), .RST_VAL(RST_VAL)) u_stat (
    .clk(clk), .rst_n(rst_n), .load(load), .nzcv_in(nzcv), .status_q(status_q));

  p_zero_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_sel |-> zer[1] && !nan[1] && !sgn[1]);
endmodule

// File: tb/sim_fpcmp_flag_unit.sv
`timescale 1ns/1ps
module sim_fpcmp_flag_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 0, dbl_sel = 0, zero_sel = 0, pred_ok = 0;
  logic [31:0] a_lo = 0, a_hi = 0, b_lo = 0, b_hi = 0;
  logic [31:0] status_q;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] model = 32'h0;

  always #10 clk = ~clk;

  fpcmp_flag_unit u0 (.*);

  function automatic real sp_val(logic [31:0] w);
    int e; real v;
    e = int'(w[30:23]);
    if (e == 255) begin
      if (w[22:0] != 0) return $bitstoreal(64'h7FF8_0000_0000_0000);
      v = $bitstoreal(64'h7FF0_0000_0000_0000);
    end else if (e == 0) v = real'(w[22:0]) * (2.0 ** (-149));
    else v = (8388608.0 + real'(w[22:0])) * (2.0 ** (e - 150));
    return w[31] ? -v : v;
  endfunction

  function automatic logic [3:0] ref_flags(logic d, z, logic [31:0] al, ah, bl, bh);
    real x, y;
    x = d ? $bitstoreal({ah, al}) : sp_val(al);
    y = z ? 0.0 : (d ? $bitstoreal({bh, bl}) : sp_val(bl));
    if (x == y) return 4'b0110;
    else if (x < y) return 4'b1000;
    else if (x > y) return 4'b0010;
    else return 4'b0011;
  endfunction

  task automatic check(string tag, logic [31:0] exp_v);
    total++;
    if (status_q !== exp_v) begin
      bad++;
      $display("FAIL %s: status_q=%08h expected=%08h", tag, status_q, exp_v);
    end
  endtask

  task automatic step(logic v, d, z, p, logic [31:0] al, ah, bl, bh, string tag);
    @(negedge clk);
    op_valid = v; dbl_sel = d; zero_sel = z; pred_ok = p;
    a_lo = al; a_hi = ah; b_lo = bl; b_hi = bh;
    if (v && p) model[31:28] = ref_flags(d, z, al, ah, bl, bh);
    @(posedge clk); #1;
    check(tag, model);
  endtask

  function automatic logic [31:0] pick_word(int sel, logic [31:0] other);
    case (sel)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return other;
      3: return other ^ 32'h8000_0000;
      4: return 32'h7F80_0000;
      5: return 32'h7F80_0001;
      6: return 32'hFFF0_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: requirement none, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check("R11 reset value", 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R11 after release", 32'h0);
    // single precision
    step(1,0,0,1, 32'h3F80_0000,0, 32'h3F80_0000,0, "R1 equal sp");
    step(1,0,0,1, 32'h3F80_0000,0, 32'h4000_0000,0, "R2 less sp");
    step(1,0,0,1, 32'h4000_0000,0, 32'h3F80_0000,0, "R3 greater sp");
    step(1,0,0,1, 32'h7FC0_0000,0, 32'h3F80_0000,0, "R4 nan first");
    step(1,0,0,1, 32'h3F80_0000,0, 32'h7F80_0001,0, "R4 nan second");
    step(1,0,0,1, 32'h7F80_0000,0, 32'h7F80_0000,0, "R6 inf equal");
    step(1,0,0,1, 32'h0000_0000,0, 32'h8000_0000,0, "R5 +0 vs -0");
    step(1,0,0,1, 32'hC000_0000,0, 32'hBF80_0000,0, "R6 neg larger mag less");
    step(1,0,0,1, 32'hBF80_0000,0, 32'hC000_0000,0, "R6 neg smaller mag greater");
    step(1,0,0,1, 32'hFF80_0000,0, 32'hFF7F_FFFF,0, "R6 -inf below max neg");
    step(1,0,0,1, 32'h8000_0001,0, 32'h0000_0000,0, "R6 neg denormal below zero");
    step(1,0,0,1, 32'h3F80_0000,32'hFFFF_FFFF, 32'h3F80_0000,32'h1234_5678, "R7 sp ignores hi");
    // double precision
    step(1,1,0,1, 0,32'h3FF0_0000, 1,32'h3FF0_0000, "R7 dp low word decides");
    step(1,1,0,1, 32'hFFFF_FFFF,32'h3FF0_0000, 0,32'h4000_0000, "R7 dp high word dominates");
    step(1,1,0,1, 0,32'h8000_0000, 0,0, "R5 dp signed zero");
    step(1,1,0,1, 1,32'h7FF0_0000, 0,32'h3FF0_0000, "R4 dp nan low mantissa");
    step(1,1,0,1, 0,32'hC000_0000, 0,32'hBFF0_0000, "R6 dp negative order");
    // zero mode
    step(1,0,1,1, 32'h3F80_0000,0, 32'h3F80_0000,0, "R8 zero mode ignores b");
    step(1,0,1,1, 32'h8000_0000,0, 32'h7FC0_0000,0, "R8 zero mode -0 equal");
    step(1,1,1,1, 0,32'hBFF0_0000, 0,32'hBFF0_0000, "R8 dp zero mode less");
    step(1,1,1,1, 0,32'h7FF8_0000, 0,0, "R8 dp zero mode nan");
    // hold cases
    step(1,0,0,1, 32'h3F80_0000,0, 32'h4000_0000,0, "R2 setup");
    step(1,0,0,0, 32'h4000_0000,0, 32'h3F80_0000,0, "R9 pred fail holds");
    step(0,0,0,1, 32'h3F80_0000,0, 32'h3F80_0000,0, "R9 no valid holds");
    step(1,0,0,1, 32'h3F80_0000,0, 32'h3F80_0000,0, "R10 next-edge update");
    // mixed patterns
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] al, ah, bl, bh;
      logic d, z, v, p;
      string tag;
      logic [3:0] f;
      d = 1'($urandom); z = ($urandom % 8) == 0;
      v = ($urandom % 8) != 0; p = ($urandom % 8) != 0;
      al = $urandom; ah = pick_word(int'($urandom % 10), 32'h3FF0_0000);
      if (d) begin
        bh = pick_word(int'($urandom % 10), ah);
        bl = (($urandom % 2) == 0) ? al : $urandom;
      end else begin
        al = pick_word(int'($urandom % 10), 32'h3F80_0000);
        bl = pick_word(int'($urandom % 10), al);
        bh = $urandom;
      end
      f = ref_flags(d, z, al, ah, bl, bh);
      if (!(v && p)) tag = "R9 random hold";
      else if (f == 4'b0110) tag = "R1 random";
      else if (f == 4'b1000) tag = "R2 random";
      else if (f == 4'b0010) tag = "R3 random";
      else tag = "R4 random";
      step(v, d, z, p, al, ah, bl, bh, tag);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule